// File: doc/BRIEF.md
# Sampling Converter Capture Controller

This block sits on the host side of a 12-bit sampling converter that has a parallel output. It paces conversions by driving a single start pulse at a programmable interval. The rising edge of that pulse is the sample instant. The interval is never shorter than one conversion time, and the pulse high and low widths are enforced in clock cycles.

Every signal coming back from the converter passes through a synchronizer: the end-of-conversion strobe, the twelve data bits, the true and inverted top bits, and the overrange flag. The strobe is then edge-detected. The block captures the result word on either the rising or the falling edge of the strobe. It reformats the word to offset binary or twos complement, classifies overrange as high or low, optionally clamps to full scale, and presents the result on a valid/ready stream.

A watchdog flags a conversion whose end-of-conversion strobe never arrives. A second sticky flag records results that were overwritten before the consumer took them.

Top module: `adc_capture_ctrl`

## Requirements
- R1: Each conversion gets exactly one start pulse on conv_start_o, high for HIGH_CYC clock cycles (default 3 cycles, 24 ns).
- R2: Successive start rising edges are exactly max(period_i, MIN_PER_CYC) cycles apart (default minimum 100 cycles, 800 ns), provided the previous conversion has finished.
- R3: While en_i is low, no start pulse is issued.
- R4: With cap_fall_i low, the word is captured on the synchronized rising edge of dav_i, and res_valid_o rises while dav_i is still high.
- R5: With cap_fall_i high, nothing is captured at the rising edge of dav_i. The word present at the falling edge is captured, and later data changes do not affect it.
- R6: data_i[11] is the converter's most significant bit and data_i[0] its LSB. Offset binary (twos_i=0) outputs data_i unchanged. Twos complement (twos_i=1) outputs {msb_n_i, data_i[10:0]}.
- R7: res_ovr_o is 2'b10 when otr_i=1 and msb_i=1, 2'b01 when otr_i=1 and msb_i=0, and 2'b00 when otr_i=0.
- R8: With sat_en_i high, a high overrange forces 12'hFFF in offset binary or 12'h7FF in twos complement. A low overrange forces 12'h000 or 12'h800 respectively. With sat_en_i low, the word passes through.
- R9: If no dav_i rising edge arrives within timeout_i cycles after a start, timeout_err_o sets and stays set, no result is emitted for that sample, and pacing resumes.
- R10: A capture made while the previous result is still unaccepted sets the sticky overflow_o, and the newer result replaces the older.
- R11: After reset, conv_start_o, res_valid_o, timeout_err_o and overflow_o are all low.
- R12: res_valid_o remains high until a cycle with res_ready_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables conversion pacing |
| period_i | input | PER_W | Cycles between start pulses |
| timeout_i | input | TO_W | Cycles allowed from start to end of conversion |
| twos_i | input | 1 | 1: twos complement, 0: offset binary |
| sat_en_i | input | 1 | Clamp overrange results to full scale |
| cap_fall_i | input | 1 | 1: capture on falling edge of dav_i |
| conv_start_o | output | 1 | Conversion start pulse to converter |
| dav_i | input | 1 | Converter data-available strobe |
| data_i | input | 12 | Converter data bits, [11] most significant |
| msb_i | input | 1 | Converter true top bit |
| msb_n_i | input | 1 | Converter inverted top bit |
| otr_i | input | 1 | Converter out-of-range flag |
| res_data_o | output | 12 | Result word |
| res_ovr_o | output | 2 | Overrange kind: 00 none, 01 low, 10 high |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Consumer accepts result |
| timeout_err_o | output | 1 | Sticky missing end-of-conversion error |
| overflow_o | output | 1 | Sticky overwritten-result flag |

## Verification
The hardest state to reach from the ports is a capture that lands on a result the consumer still holds. Reaching it takes two complete conversions with the ready line held low throughout, because the pacing rule keeps captures at least one conversion period apart. The bench runs two full conversion handshakes back to back with ready parked low, then checks that the second word took the first one's place. Falling-edge capture is also hard to observe: the bench moves the data lines shortly after lowering the strobe, so a capture at the wrong edge or a late one returns the wrong word.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int unsigned WORD_W = 12;

  typedef enum logic [1:0] {
    OVR_NONE = 2'b00,
    OVR_LOW  = 2'b01,
    OVR_HIGH = 2'b10
  } ovr_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_EOC,
    ST_WAIT_FALL
  } cap_st_e;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    ovr_e              ovr;
  } result_t;
endpackage

// File: rtl/acc_start_gen.sv
module acc_start_gen #(
  parameter int unsigned PER_W       = 16,
  parameter int unsigned HIGH_CYC    = 3,
  parameter int unsigned MIN_PER_CYC = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             idle_i,
  input  logic [PER_W-1:0] period_i,
  output logic             fire_o,
  output logic             start_o
);
  localparam logic [PER_W-1:0] MIN_P  = PER_W'(MIN_PER_CYC);
  localparam int unsigned      HC_W   = (HIGH_CYC > 1) ? $clog2(HIGH_CYC) : 1;
  localparam logic [HC_W-1:0]  HC_TOP = HC_W'(HIGH_CYC - 1);

  logic [PER_W-1:0] eff_per, per_cnt_q;
  logic [HC_W-1:0]  hi_cnt_q;

  // clamp the requested interval to one conversion time
  assign eff_per = (period_i < MIN_P) ? MIN_P : period_i;
  assign fire_o  = en_i && idle_i && (per_cnt_q >= eff_per - PER_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_cnt_q <= '0;
    end else if (fire_o) begin
      per_cnt_q <= '0;
    end else if (per_cnt_q != '1) begin
      per_cnt_q <= per_cnt_q + PER_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o  <= 1'b0;
      hi_cnt_q <= '0;
    end else if (fire_o) begin
      start_o  <= 1'b1;
      hi_cnt_q <= HC_TOP;
    end else if (hi_cnt_q != '0) begin
      hi_cnt_q <= hi_cnt_q - HC_W'(1);
    end else begin
      start_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/acc_sync_edge.sv
module acc_sync_edge #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] sync_o,
  output logic         rise_o,
  output logic         fall_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic                     edge_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else if (i == 0) stg_q[i] <= in_i;
      else stg_q[i] <= stg_q[(i > 0) ? i - 1 : 0];
    end
  end

  assign sync_o = stg_q[STAGES-1];

  // bit 0 carries the strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edge_q <= 1'b0;
    else edge_q <= sync_o[0];
  end

  assign rise_o = sync_o[0] && !edge_q;
  assign fall_o = !sync_o[0] && edge_q;
endmodule

// File: rtl/acc_fmt.sv
module acc_fmt
  import adc_cap_pkg::*;
(
  input  logic [WORD_W-1:0] raw_i,
  input  logic              msb_i,
  input  logic              msb_n_i,
  input  logic              otr_i,
  input  logic              twos_i,
  input  logic              sat_en_i,
  output result_t           res_o
);
  logic [WORD_W-1:0] word, pos_fs, neg_fs;
  ovr_e              kind;

  always_comb begin
    word   = twos_i ? {msb_n_i, raw_i[WORD_W-2:0]} : raw_i;
    pos_fs = twos_i ? {1'b0, {(WORD_W-1){1'b1}}} : {WORD_W{1'b1}};
    neg_fs = twos_i ? {1'b1, {(WORD_W-1){1'b0}}} : {WORD_W{1'b0}};
    if (!otr_i)     kind = OVR_NONE;
    else if (msb_i) kind = OVR_HIGH;
    else            kind = OVR_LOW;

    res_o.ovr  = kind;
    res_o.data = word;
    if (sat_en_i && kind == OVR_HIGH) res_o.data = pos_fs;
    if (sat_en_i && kind == OVR_LOW)  res_o.data = neg_fs;
  end
endmodule

// File: rtl/acc_out_reg.sv
module acc_out_reg
  import adc_cap_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    load_i,
  input  result_t res_i,
  input  logic    ready_i,
  output logic    valid_o,
  output result_t res_o,
  output logic    overflow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      res_o      <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (load_i) begin
        res_o   <= res_i;
        valid_o <= 1'b1;
        if (valid_o && !ready_i) overflow_o <= 1'b1;
      end else if (ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl
  import adc_cap_pkg::*;
#(
  parameter int unsigned PER_W       = 16,
  parameter int unsigned TO_W        = 16,
  parameter int unsigned HIGH_CYC    = 3,
  parameter int unsigned MIN_PER_CYC = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [TO_W-1:0]   timeout_i,
  input  logic              twos_i,
  input  logic              sat_en_i,
  input  logic              cap_fall_i,
  output logic              conv_start_o,
  input  logic              dav_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              msb_i,
  input  logic              msb_n_i,
  input  logic              otr_i,
  output logic [WORD_W-1:0] res_data_o,
  output logic [1:0]        res_ovr_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic              timeout_err_o,
  output logic              overflow_o
);
  localparam int unsigned SYNC_W = WORD_W + 4;

  logic              fire, idle, dav_rise, dav_fall, cap, to_hit;
  logic [SYNC_W-1:0] s_bus;
  logic [TO_W-1:0]   to_cnt_q;
  cap_st_e           st_q, st_d;
  result_t           fmt_res, out_res;

  assign idle = (st_q == ST_IDLE);

  acc_start_gen #(
    .PER_W      (PER_W),
    .HIGH_CYC   (HIGH_CYC),
    .MIN_PER_CYC(MIN_PER_CYC)
  ) u_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .idle_i  (idle),
    .period_i(period_i),
    .fire_o  (fire),
    .start_o (conv_start_o)
  );

  acc_sync_edge #(
    .W     (SYNC_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({data_i, otr_i, msb_n_i, msb_i, dav_i}),
    .sync_o(s_bus),
    .rise_o(dav_rise),
    .fall_o(dav_fall)
  );

  acc_fmt u_fmt (
    .raw_i   (s_bus[SYNC_W-1:4]),
    .msb_i   (s_bus[1]),
    .msb_n_i (s_bus[2]),
    .otr_i   (s_bus[3]),
    .twos_i  (twos_i),
    .sat_en_i(sat_en_i),
    .res_o   (fmt_res)
  );

  always_comb begin
    st_d   = st_q;
    cap    = 1'b0;
    to_hit = 1'b0;
    unique case (st_q)
      ST_IDLE: if (fire) st_d = ST_WAIT_EOC;
      ST_WAIT_EOC: begin
        if (dav_rise) begin
          if (cap_fall_i) begin
            st_d = ST_WAIT_FALL;
          end else begin
            cap  = 1'b1;
            st_d = ST_IDLE;
          end
        end else if (to_cnt_q >= timeout_i) begin
          to_hit = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      ST_WAIT_FALL: begin
        if (dav_fall) begin
          cap  = 1'b1;
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      to_cnt_q      <= '0;
      timeout_err_o <= 1'b0;
    end else begin
      st_q <= st_d;
      if (fire) to_cnt_q <= '0;
      else if (st_q == ST_WAIT_EOC && to_cnt_q != '1) to_cnt_q <= to_cnt_q + TO_W'(1);
      if (to_hit) timeout_err_o <= 1'b1;
    end
  end

  acc_out_reg u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cap),
    .res_i     (fmt_res),
    .ready_i   (res_ready_i),
    .valid_o   (res_valid_o),
    .res_o     (out_res),
    .overflow_o(overflow_o)
  );

  assign res_data_o = out_res.data;
  assign res_ovr_o  = out_res.ovr;
endmodule

// File: rtl/acc_checker.sv
module acc_checker #(
  parameter int unsigned MIN_PER_CYC = 100
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        twos_i,
  input logic        sat_en_i,
  input logic        conv_start_o,
  input logic [11:0] res_data_o,
  input logic [1:0]  res_ovr_o,
  input logic        res_valid_o,
  input logic        res_ready_i,
  input logic        timeout_err_o,
  input logic        overflow_o
);
  logic        prev_q, seen_q;
  logic [31:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      prev_q <= conv_start_o;
      if (conv_start_o && !prev_q) begin
        seen_q <= 1'b1;
        gap_q  <= 32'd1;
      end else if (gap_q != '1) begin
        gap_q  <= gap_q + 32'd1;
      end
    end
  end

  p_min_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start_o && !prev_q && seen_q) |-> (gap_q >= MIN_PER_CYC));

  p_start_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start_o && !prev_q) |-> $past(en_i));

  p_ovr_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_ovr_o != 2'b11));

  p_sat_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && sat_en_i && !twos_i && res_ovr_o == 2'b10) |-> (res_data_o == 12'hFFF));

  p_timeout_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_err_o |=> timeout_err_o);

  p_overflow_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  p_valid_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> res_valid_o);
endmodule

bind adc_capture_ctrl acc_checker #(.MIN_PER_CYC(MIN_PER_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .twos_i       (twos_i),
  .sat_en_i     (sat_en_i),
  .conv_start_o (conv_start_o),
  .res_data_o   (res_data_o),
  .res_ovr_o    (res_ovr_o),
  .res_valid_o  (res_valid_o),
  .res_ready_i  (res_ready_i),
  .timeout_err_o(timeout_err_o),
  .overflow_o   (overflow_o)
);

// File: tb/test_adc_capture_ctrl.sv
`timescale 1ns/1ps
module test_adc_capture_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] period = 16'd150;
  logic [15:0] tmo = 16'd40;
  logic        twos = 1'b0, sat = 1'b0, cap_fall = 1'b0;
  logic        start;
  logic        dav = 1'b0;
  logic [11:0] din = '0;
  logic        msb = 1'b0, msb_n = 1'b1, otr = 1'b0;
  logic [11:0] rdata;
  logic [1:0]  rovr;
  logic        rvalid, rready = 1'b0, terr, ovf;

  int total = 0, bad = 0, cyc = 0;
  int last_start = 0, last_gap = 0, last_hw = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_capture_ctrl i_adc_capture_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .period_i(period), .timeout_i(tmo),
    .twos_i(twos), .sat_en_i(sat), .cap_fall_i(cap_fall), .conv_start_o(start),
    .dav_i(dav), .data_i(din), .msb_i(msb), .msb_n_i(msb_n), .otr_i(otr),
    .res_data_o(rdata), .res_ovr_o(rovr), .res_valid_o(rvalid), .res_ready_i(rready),
    .timeout_err_o(terr), .overflow_o(ovf)
  );

  typedef struct packed {
    logic        tw;
    logic        st;
    logic        ot;
    logic [11:0] d;
    logic [11:0] ed;
    logic [1:0]  eo;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b0, 1'b0, 1'b0, 12'h123, 12'h123, 2'b00},
    '{1'b1, 1'b0, 1'b0, 12'h123, 12'h923, 2'b00},
    '{1'b1, 1'b0, 1'b0, 12'hABC, 12'h2BC, 2'b00},
    '{1'b0, 1'b0, 1'b1, 12'hFFF, 12'hFFF, 2'b10},
    '{1'b0, 1'b1, 1'b1, 12'hF00, 12'hFFF, 2'b10},
    '{1'b1, 1'b1, 1'b1, 12'hF00, 12'h7FF, 2'b10},
    '{1'b0, 1'b1, 1'b1, 12'h005, 12'h000, 2'b01},
    '{1'b1, 1'b1, 1'b1, 12'h005, 12'h800, 2'b01},
    '{1'b1, 1'b0, 1'b1, 12'h005, 12'h805, 2'b01},
    '{1'b0, 1'b0, 1'b0, 12'h800, 12'h800, 2'b00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_start();
    bit prev = start;
    bit got = 0;
    for (int i = 0; i < 2000 && !got; i++) begin
      @(negedge clk);
      if (start && !prev) got = 1;
      prev = start;
    end
    chk("R1 start seen", got, 1);
    last_gap = cyc - last_start;
    last_start = cyc;
    last_hw = 0;
    while (start && last_hw < 50) begin
      last_hw++;
      @(negedge clk);
    end
  endtask

  // answer one conversion; fall_mode picks which check is made while dav is high
  task automatic convert(input logic [11:0] d, input logic ot, input bit fall_mode);
    wait_start();
    din = d; msb = d[11]; msb_n = ~d[11]; otr = ot;
    repeat (2) @(negedge clk);
    dav = 1'b1;
    repeat (5) @(negedge clk);
    if (fall_mode) chk("R5 no capture on rise", rvalid, 0);
    else           chk("R4 captured while dav high", rvalid, 1);
    @(negedge clk);
    dav = 1'b0;
    repeat (5) @(negedge clk);
    din = ~d; msb = ~d[11]; msb_n = d[11]; otr = ~ot;
  endtask

  task automatic take(input string req, input logic [11:0] ed, input logic [1:0] eo);
    for (int i = 0; i < 50 && !rvalid; i++) @(negedge clk);
    chk(req, rvalid, 1);
    chk(req, rdata, ed);
    chk(req, rovr, eo);
    rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
    chk("R12 valid drops after accept", rvalid, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 start low", start, 0);
    chk("R11 valid low", rvalid, 0);
    chk("R11 timeout low", terr, 0);
    chk("R11 overflow low", ovf, 0);
    rst_n = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (start) seen++;
      end
      chk("R3 no start while disabled", seen, 0);
    end
    en = 1'b1;

    // main table
    for (int k = 0; k < 10; k++) begin
      twos = VEC[k].tw; sat = VEC[k].st;
      convert(VEC[k].d, VEC[k].ot, 0);
      chk("R1 pulse width", last_hw, 3);
      if (k == 1) chk("R2 gap equals period_i", last_gap, 150);
      if (k == 2) chk("R2 gap clamped to minimum", last_gap, 100);
      if (k == 1) period = 16'd10;
      take("R6 R7 R8 table vector", VEC[k].ed, VEC[k].eo);
    end

    // falling-edge capture
    cap_fall = 1'b1; twos = 1'b0; sat = 1'b0;
    convert(12'h456, 1'b0, 1);
    take("R5 falling-edge word", 12'h456, 2'b00);
    cap_fall = 1'b0;

    // missing end of conversion
    chk("R9 no error yet", terr, 0);
    wait_start();
    repeat (60) @(negedge clk);
    chk("R9 timeout flagged", terr, 1);
    chk("R9 no result emitted", rvalid, 0);
    convert(12'h321, 1'b0, 0);
    take("R9 pacing resumes", 12'h321, 2'b00);
    chk("R9 timeout sticky", terr, 1);

    // overwrite of an unaccepted result
    chk("R10 no overflow yet", ovf, 0);
    convert(12'h111, 1'b0, 0);
    convert(12'h222, 1'b0, 0);
    repeat (4) @(negedge clk);
    chk("R10 overflow flagged", ovf, 1);
    chk("R12 still valid", rvalid, 1);
    take("R10 newer word kept", 12'h222, 2'b00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule